// File: doc/BRIEF.md
# Source Capability Current Calculator

This block works out the largest current a USB Power Delivery source may offer with each of its three fixed supply voltages. A two-bit code picks the port's power budget and a second input picks the current ceiling; both are captured once, on the first clock after reset is released, and are then held. A third input selects full or half budget. It is watched on every cycle, and any change to it starts a fresh calculation of all three currents.

Each current is the budget divided by the voltage, truncated to whole 10 mA steps and limited by the ceiling. The 5 V entry never drops below 3 A. A restoring divider works through the three voltages one after another. The new values are committed together, and a one-cycle done strobe follows. A sink-attach input must stay high through a debounce window and then a settle window before real values are offered. Until then the outputs carry only the default Type-C current on the 5 V entry. A level change made while the port is offering real values ends in a one-cycle request to re-send capabilities.

Top module: `pdo_current_calc`

## Requirements
- R1: The budget code maps as follows: 0 selects 36 W, 1 selects 45 W, 2 selects 65 W and 3 selects 93 W.
- R2: With `full_pwr_i` high the whole selected budget is used. With it low, every entry uses half of the budget.
- R3: With `cap3a_i` high the ceiling is 300 (3 A). With it low the ceiling is 500 (5 A). No offered value ever exceeds the ceiling.
- R4: Entry k equals min(floor(budget_W*100 / V_k), ceiling) in 10 mA units. With VARIANT=0, entries 0, 1 and 2 are 5 V, 12 V and 20 V. With VARIANT=1 they are 5 V, 9 V and 15 V.
- R5: Entry 0 (5 V) is never below 300 while the port is ready.
- R6: The budget code and `cap3a_i` are sampled on the first rising edge after reset is released. Later changes to them have no effect until the next reset.
- R7: After reset, and after every change of `full_pwr_i`, all three entries are recomputed. `calc_done_o` is high for exactly one cycle when all three new values are in place.
- R8: `reneg_o` is a one-cycle pulse, one cycle after `calc_done_o`. It fires only for a recomputation caused by a level change, only while `adv_ready_o` is high, and only if the level has not changed again in the meantime. A change made while the port is not ready gives no pulse.
- R9: While `adv_ready_o` is low, `cur0_o` equals DEFAULT_CUR (default 50, i.e. 500 mA), and `cur1_o` and `cur2_o` are 0.
- R10: `adv_ready_o` rises after `attach_i` has been sampled high on DEB_CYC+SETTLE_CYC consecutive rising edges, provided a first result exists. It drops on the edge that samples `attach_i` low.
- R11: The offered values change only when a calculation completes. They do not change while a calculation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_code_i | input | 2 | Budget code, sampled once after reset |
| cap3a_i | input | 1 | High limits current to 3 A, sampled once after reset |
| full_pwr_i | input | 1 | Live budget level: high for full, low for half |
| attach_i | input | 1 | Raw sink-attached indication |
| cur0_o | output | 10 | 5 V entry current, 10 mA units |
| cur1_o | output | 10 | Middle voltage entry current, 10 mA units |
| cur2_o | output | 10 | Highest voltage entry current, 10 mA units |
| adv_ready_o | output | 1 | Real capabilities are being offered |
| calc_busy_o | output | 1 | A calculation is in progress |
| calc_done_o | output | 1 | One-cycle strobe: all entries updated |
| reneg_o | output | 1 | One-cycle request to re-send capabilities |

## Verification
The bench builds the block with VARIANT=0 (5, 12 and 20 V), DEB_CYC=8, SETTLE_CYC=12 and DEFAULT_CUR=50. The short windows let each reset-and-attach cycle finish in a few dozen clocks, so all four budget codes, both ceilings and both levels can each be tried from their own reset. The same short windows make it possible to count the edge on which ready rises. The 9 V and 15 V variant differs only in its voltage constants and is not built here.

// File: rtl/pdo_calc_pkg.sv
// Shared constants, types and helper functions for the source capability
// current calculator. Assumes budgets are whole watts and voltages whole volts.
package pdo_calc_pkg;

    localparam int MAX_WATTS = 93;
    localparam int N_PDO     = 3;
    localparam int CUR_W     = 10;
    localparam int NUM_W     = $clog2(MAX_WATTS * 100 + 1);
    localparam int DEN_W     = 5;
    localparam int IDX_W     = $clog2(N_PDO);

    localparam logic [CUR_W-1:0] CEIL_3A   = CUR_W'(300);
    localparam logic [CUR_W-1:0] CEIL_5A   = CUR_W'(500);
    localparam logic [CUR_W-1:0] FLOOR_5V  = CUR_W'(300);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_WAIT
    } eng_state_t;

    // Budget in units of 10 mW per volt of divisor (watts*100 full, watts*50 half).
    function automatic logic [NUM_W-1:0] budget_scaled(input logic [1:0] code,
                                                       input logic       full);
        int watts;
        case (code)
            2'd0:    watts = 36;
            2'd1:    watts = 45;
            2'd2:    watts = 65;
            default: watts = 93;
        endcase
        return full ? NUM_W'(watts * 100) : NUM_W'(watts * 50);
    endfunction

    // Voltage of entry idx for the chosen voltage set.
    function automatic logic [DEN_W-1:0] volt_of(input int variant,
                                                 input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(0): return DEN_W'(5);
            IDX_W'(1): return (variant != 0) ? DEN_W'(9)  : DEN_W'(12);
            default:   return (variant != 0) ? DEN_W'(15) : DEN_W'(20);
        endcase
    endfunction

endpackage

// File: rtl/pdo_cfg_latch.sv
// Captures the budget code and the 3 A ceiling select on the first rising
// edge after reset release and holds them until the next reset.
// Assumes both inputs are settled while reset is asserted.
module pdo_cfg_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_i,
    input  logic       cap3a_i,
    output logic [1:0] code_o,
    output logic       cap3a_o,
    output logic       vld_o
);

    // One-shot capture of the static configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            code_o  <= 2'd0;
            cap3a_o <= 1'b0;
        end else if (!vld_o) begin
            vld_o   <= 1'b1;
            code_o  <= code_i;
            cap3a_o <= cap3a_i;
        end
    end

endmodule

// File: rtl/pdo_attach_gate.sv
// Qualifies the raw attach input: it must stay high for DEB_CYC edges
// (debounce) and then SETTLE_CYC more edges (supply settle) before ready.
// Any low sample clears the sequence at once. Assumes attach_i is synchronous.
module pdo_attach_gate #(
    parameter int DEB_CYC    = 8,
    parameter int SETTLE_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic attach_i,
    output logic ready_o
);

    localparam int MAX_CYC = (DEB_CYC > SETTLE_CYC) ? DEB_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             in_settle;

    // Two-phase window counter: debounce first, then settle, then hold ready.
    always_ff @(posedge clk) begin
        if (!rst_n || !attach_i) begin
            cnt       <= '0;
            in_settle <= 1'b0;
            ready_o   <= 1'b0;
        end else if (!ready_o) begin
            if (!in_settle) begin
                if (cnt == CNT_W'(DEB_CYC - 1)) begin
                    in_settle <= 1'b1;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
                ready_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdo_seq_div.sv
// Restoring unsigned divider: one quotient bit per cycle, NUM_W cycles after
// the start cycle, then a one-cycle done. Assumes den_i is non-zero and that
// start_i is not raised while a division is running.
module pdo_seq_div #(
    parameter int NUM_W = 14,
    parameter int DEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             done_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             bit_n;
    logic [DEN_W-1:0] rem_n;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial = {rem_q, quo_o[NUM_W-1]};
        if (trial >= {1'b0, den_q}) begin
            bit_n = 1'b1;
            rem_n = DEN_W'(trial - {1'b0, den_q});
        end else begin
            bit_n = 1'b0;
            rem_n = trial[DEN_W-1:0];
        end
    end

    // Iteration control and quotient/remainder registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_o  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                quo_o <= num_i;
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_o <= {quo_o[NUM_W-2:0], bit_n};
                rem_q <= rem_n;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(NUM_W - 1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pdo_cur_engine.sv
// Sequences the divider over the voltage entries, applies the ceiling and the
// 5 V floor, and commits all entries together. It starts once the configuration
// is valid and again whenever the live level differs from the level last used.
module pdo_cur_engine
    import pdo_calc_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_vld_i,
    input  logic [1:0]                  code_i,
    input  logic                        cap3a_i,
    input  logic                        full_i,
    output logic [N_PDO-1:0][CUR_W-1:0] cur_o,
    output logic                        valid_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        trig_chg_o,
    output logic                        lvl_used_o
);

    eng_state_t                  state;
    logic [IDX_W-1:0]            idx;
    logic                        have_run;
    logic [N_PDO-1:0][CUR_W-1:0] shd;
    logic                        start;
    logic                        div_start;
    logic [NUM_W-1:0]            div_num;
    logic [DEN_W-1:0]            div_den;
    logic [NUM_W-1:0]            div_quo;
    logic                        div_done;
    logic [CUR_W-1:0]            ceil_v;
    logic [CUR_W-1:0]            entry;

    assign busy_o    = (state != ENG_IDLE);
    assign start     = cfg_vld_i && (state == ENG_IDLE) &&
                       (!have_run || (full_i != lvl_used_o));
    assign div_start = (state == ENG_LOAD);
    assign div_num   = budget_scaled(code_i, lvl_used_o);
    assign div_den   = volt_of(VARIANT, idx);
    assign ceil_v    = cap3a_i ? CEIL_3A : CEIL_5A;

    pdo_seq_div #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .quo_o   (div_quo),
        .done_o  (div_done)
    );

    // Limit the quotient to the ceiling, then lift the 5 V entry to its floor.
    always_comb begin
        if (div_quo > NUM_W'(ceil_v)) entry = ceil_v;
        else                          entry = div_quo[CUR_W-1:0];
        if ((idx == '0) && (entry < FLOOR_5V)) entry = FLOOR_5V;
    end

    // Calculation sequencer with shadow storage and atomic commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            idx        <= '0;
            have_run   <= 1'b0;
            lvl_used_o <= 1'b0;
            trig_chg_o <= 1'b0;
            done_o     <= 1'b0;
            valid_o    <= 1'b0;
            shd        <= '0;
            cur_o      <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state      <= ENG_LOAD;
                        idx        <= '0;
                        lvl_used_o <= full_i;
                        trig_chg_o <= have_run;
                        have_run   <= 1'b1;
                    end
                end
                ENG_LOAD: state <= ENG_WAIT;
                ENG_WAIT: begin
                    if (div_done) begin
                        if (idx == IDX_W'(N_PDO - 1)) begin
                            for (int i = 0; i < N_PDO - 1; i++) cur_o[i] <= shd[i];
                            cur_o[N_PDO-1] <= entry;
                            done_o  <= 1'b1;
                            valid_o <= 1'b1;
                            state   <= ENG_IDLE;
                        end else begin
                            shd[idx] <= entry;
                            idx      <= idx + 1'b1;
                            state    <= ENG_LOAD;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pdo_current_calc.sv
// Top of the source capability current calculator. Ties together the config
// capture, the attach qualifier and the calculation engine, gates the offered
// values on readiness and produces the re-advertise pulse.
// Assumes all inputs are synchronous to clk.
module pdo_current_calc
    import pdo_calc_pkg::*;
#(
    parameter int VARIANT     = 0,
    parameter int DEB_CYC     = 8,
    parameter int SETTLE_CYC  = 12,
    parameter int DEFAULT_CUR = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pwr_code_i,
    input  logic             cap3a_i,
    input  logic             full_pwr_i,
    input  logic             attach_i,
    output logic [CUR_W-1:0] cur0_o,
    output logic [CUR_W-1:0] cur1_o,
    output logic [CUR_W-1:0] cur2_o,
    output logic             adv_ready_o,
    output logic             calc_busy_o,
    output logic             calc_done_o,
    output logic             reneg_o
);

    logic [1:0]                  cfg_code;
    logic                        cfg_cap3a;
    logic                        cfg_vld;
    logic                        gate_ready;
    logic [N_PDO-1:0][CUR_W-1:0] eng_cur;
    logic                        eng_valid;
    logic                        eng_trig;
    logic                        eng_lvl;
    logic                        reneg_q;
    logic [N_PDO-1:0][CUR_W-1:0] offer;

    pdo_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (pwr_code_i),
        .cap3a_i (cap3a_i),
        .code_o  (cfg_code),
        .cap3a_o (cfg_cap3a),
        .vld_o   (cfg_vld)
    );

    pdo_attach_gate #(
        .DEB_CYC    (DEB_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .attach_i (attach_i),
        .ready_o  (gate_ready)
    );

    pdo_cur_engine #(
        .VARIANT (VARIANT)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_vld_i  (cfg_vld),
        .code_i     (cfg_code),
        .cap3a_i    (cfg_cap3a),
        .full_i     (full_pwr_i),
        .cur_o      (eng_cur),
        .valid_o    (eng_valid),
        .busy_o     (calc_busy_o),
        .done_o     (calc_done_o),
        .trig_chg_o (eng_trig),
        .lvl_used_o (eng_lvl)
    );

    assign adv_ready_o = gate_ready && eng_valid;

    // Offered value per entry: computed when ready, default or zero otherwise.
    for (genvar g = 0; g < N_PDO; g++) begin : g_offer
        if (g == 0) begin : g_first
            assign offer[g] = adv_ready_o ? eng_cur[g] : CUR_W'(DEFAULT_CUR);
        end else begin : g_rest
            assign offer[g] = adv_ready_o ? eng_cur[g] : '0;
        end
    end

    assign cur0_o = offer[0];
    assign cur1_o = offer[1];
    assign cur2_o = offer[2];

    // Re-advertise request after a level-triggered result with no newer change.
    always_ff @(posedge clk) begin
        if (!rst_n) reneg_q <= 1'b0;
        else        reneg_q <= calc_done_o && eng_trig && (full_pwr_i == eng_lvl);
    end

    assign reneg_o = reneg_q && adv_ready_o;

endmodule

// File: rtl/pdo_current_calc_chk.sv
// Property checker for pdo_current_calc, attached by bind below.
module pdo_current_calc_chk
    import pdo_calc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   adv_ready,
    input logic [CUR_W-1:0]       cur0,
    input logic [CUR_W-1:0]       cur1,
    input logic [CUR_W-1:0]       cur2,
    input logic                   cap3a_q,
    input logic [1:0]             code_q,
    input logic                   cfg_vld,
    input logic                   busy,
    input logic                   done,
    input logic                   reneg,
    input logic [N_PDO*CUR_W-1:0] com
);

    logic [CUR_W-1:0] ceil_v;
    assign ceil_v = cap3a_q ? CEIL_3A : CEIL_5A;

    assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ready |-> (cur0 <= ceil_v) && (cur1 <= ceil_v) && (cur2 <= ceil_v));

    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ready |-> (cur0 >= FLOOR_5V));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vld && $past(cfg_vld)) |-> ($stable(code_q) && $stable(cap3a_q)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_reneg_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reneg |=> !reneg);

    assert_reneg_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reneg |-> adv_ready);

    assert_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_ready |-> (cur1 == '0) && (cur2 == '0));

    assert_atomic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(com));

endmodule

bind pdo_current_calc pdo_current_calc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_ready (adv_ready_o),
    .cur0      (cur0_o),
    .cur1      (cur1_o),
    .cur2      (cur2_o),
    .cap3a_q   (cfg_cap3a),
    .code_q    (cfg_code),
    .cfg_vld   (cfg_vld),
    .busy      (calc_busy_o),
    .done      (calc_done_o),
    .reneg     (reneg_o),
    .com       (eng_cur)
);

// File: tb/pdo_current_calc_bench.sv
module pdo_current_calc_bench;

    localparam int DEB = 8;
    localparam int SET = 12;
    localparam int NV  = 9;

    // {code, cap3a, full, exp0, exp1, exp2} for the 5/12/20 V set
    localparam logic [33:0] VEC [NV] = '{
        {2'd3, 1'b0, 1'b1, 10'd500, 10'd500, 10'd465},
        {2'd3, 1'b0, 1'b0, 10'd500, 10'd387, 10'd232},
        {2'd0, 1'b0, 1'b0, 10'd360, 10'd150, 10'd90},
        {2'd0, 1'b1, 1'b0, 10'd300, 10'd150, 10'd90},
        {2'd1, 1'b0, 1'b0, 10'd450, 10'd187, 10'd112},
        {2'd2, 1'b0, 1'b1, 10'd500, 10'd500, 10'd325},
        {2'd2, 1'b1, 1'b1, 10'd300, 10'd300, 10'd300},
        {2'd1, 1'b1, 1'b1, 10'd300, 10'd300, 10'd225},
        {2'd0, 1'b0, 1'b1, 10'd500, 10'd300, 10'd180}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_code = 2'd0;
    logic       cap3a = 1'b0;
    logic       full_pwr = 1'b1;
    logic       attach = 1'b0;
    logic [9:0] cur0, cur1, cur2;
    logic       ready, busy, done, reneg;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int reneg_cnt = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    pdo_current_calc #(
        .VARIANT(0), .DEB_CYC(DEB), .SETTLE_CYC(SET), .DEFAULT_CUR(50)
    ) u_pdo_current_calc (
        .clk(clk), .rst_n(rst_n), .pwr_code_i(pwr_code), .cap3a_i(cap3a),
        .full_pwr_i(full_pwr), .attach_i(attach), .cur0_o(cur0), .cur1_o(cur1),
        .cur2_o(cur2), .adv_ready_o(ready), .calc_busy_o(busy),
        .calc_done_o(done), .reneg_o(reneg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && reneg) reneg_cnt <= reneg_cnt + 1;
        if (rst_n && done)  done_cnt  <= done_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait (cycles == 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        int c0, c1, c2;
        // Reset state, not attached (R9)
        do_reset();
        @(negedge clk);
        chk("R9 reset cur0", cur0, 50);
        chk("R9 reset cur1", cur1, 0);
        chk("R9 reset cur2", cur2, 0);
        chk("R10 reset ready", ready, 0);
        chk("R8 reset reneg", reneg, 0);

        // Vector table: every code, ceiling and level from its own reset
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {pwr_code, cap3a, full_pwr} = VEC[v][33:30];
            attach = 1'b1;
            do_reset();
            wait_ready();
            chk("R1 R2 R3 R4 entry0", cur0, int'(VEC[v][29:20]));
            chk("R1 R2 R3 R4 entry1", cur1, int'(VEC[v][19:10]));
            chk("R1 R2 R3 R4 entry2", cur2, int'(VEC[v][9:0]));
            chk("R5 floor", int'(cur0 >= 300), 1);
        end

        // R10: exact edge on which ready rises; result already present
        attach = 1'b0;
        @(negedge clk);
        chk("R10 drop on attach low", ready, 0);
        chk("R9 default when not ready", cur0, 50);
        attach = 1'b1;
        repeat (DEB + SET - 1) @(negedge clk);
        chk("R10 not yet ready", ready, 0);
        @(negedge clk);
        chk("R10 ready after windows", ready, 1);

        // Start from code 3, 5 A, full; then alter latched inputs (R6)
        pwr_code = 2'd3; cap3a = 1'b0; full_pwr = 1'b1;
        do_reset();
        wait_ready();
        idle(5);
        pwr_code = 2'd0; cap3a = 1'b1;
        r0 = reneg_cnt;
        c0 = done_cnt;
        full_pwr = 1'b0;
        idle(120);
        chk("R6 code ignored entry0", cur0, 500);
        chk("R6 code ignored entry1", cur1, 387);
        chk("R6 code ignored entry2", cur2, 232);
        chk("R7 one done per change", done_cnt - c0, 1);
        chk("R8 one reneg per change", reneg_cnt - r0, 1);

        // Change twice, second during busy: one reneg only, values stable (R8 R11)
        r0 = reneg_cnt;
        full_pwr = 1'b1;
        idle(3);
        chk("R7 busy after change", busy, 1);
        c0 = cur0; c1 = cur1; c2 = cur2;
        full_pwr = 1'b0;
        idle(10);
        chk("R11 entry1 stable while busy", cur1, c1);
        chk("R11 entry2 stable while busy", cur2, c2);
        chk("R11 entry0 stable while busy", cur0, c0);
        idle(200);
        chk("R8 suppressed intermediate", reneg_cnt - r0, 1);
        chk("R2 final half entry2", cur2, 232);

        // Change while not attached: no reneg (R8), defaults shown (R9)
        r0 = reneg_cnt;
        attach = 1'b0;
        full_pwr = 1'b1;
        idle(120);
        chk("R8 no reneg when not ready", reneg_cnt - r0, 0);
        chk("R9 cur1 zero when not ready", cur1, 0);
        attach = 1'b1;
        wait_ready();
        chk("R2 full after reattach entry2", cur2, 465);
        chk("R4 full after reattach entry1", cur1, 500);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule